// File: doc/BRIEF.md
# Sample Frame Packetizer

This block turns a bank of ten 12-bit sensor samples into a byte stream for a byte-wide serial transmitter. When a packet begins, it copies all ten samples into a snapshot register. It then sends a two-byte marker of 0xFF 0xFF, followed by two bytes per channel from channel 0 up to channel 9. Each channel's upper byte goes out before its lower byte. Each sample sits right-aligned in a 16-bit word, so its upper byte can never be 0xFF. A receiver can therefore find the packet boundary by looking for two 0xFF bytes in a row.

The output is a valid/ready stream. A byte moves only in a cycle where `tx_valid_o` and `tx_ready_i` are both high. While `tx_ready_i` is low, the block keeps `tx_valid_o` high and holds `tx_data_o` unchanged, so the transmitter can apply back-pressure for any length of time without losing a byte. There are two ways to launch packets:

- **Single-shot:** each `start_i` request launches one packet. A request that arrives during a packet is remembered and served once that packet ends.
- **Continuous:** while `continuous_i` is high, a new packet with a fresh snapshot follows each finished one after a single idle cycle.

Top module: `pkt_frame_packer`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the next cycle shows `tx_valid_o` = 0 and `frame_done_o` = 0. After reset, no byte is offered until a start request or continuous mode is seen, and the next packet begins at its first marker byte.
- R2: The first two bytes of every packet both equal 0xFF.
- R3: Byte 2+2k carries channel k's upper byte and byte 3+2k carries its lower byte, for k = 0..9 in ascending order. The upper byte is {4'h0, sample[11:8]} and the lower byte is sample[7:0]. Channel k's sample sits on `samples_i[12k+11:12k]`.
- R4: A byte advances only in a cycle where `tx_valid_o` and `tx_ready_i` are both high. While `tx_valid_o` is high and `tx_ready_i` is low, the next cycle still has `tx_valid_o` high and the same `tx_data_o`.
- R5: A packet is 22 bytes long. `frame_done_o` is high for exactly the one cycle after the 22nd byte is accepted, and `tx_valid_o` is low in that cycle.
- R6: All ten samples are captured on the edge that launches a packet. Changes on `samples_i` after that edge do not alter any byte of that packet.
- R7: With `continuous_i` high, a new packet launches on the edge that ends the `frame_done_o` cycle. Its snapshot is taken at that edge, so `tx_valid_o` is low for exactly one cycle between packets.
- R8: With the block idle, `start_i` sampled high makes `tx_valid_o` high in the next cycle. Without a further request or continuous mode, the block returns to idle after one packet.
- R9: `start_i` seen while a packet is in flight, including in the cycle its last byte is accepted, launches exactly one further packet right after the `frame_done_o` cycle. Several such requests within one packet collapse into one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| samples_i | input | 120 | Ten 12-bit samples; channel k on bits 12k+11:12k |
| continuous_i | input | 1 | High: send packets back to back |
| start_i | input | 1 | Request one packet |
| tx_data_o | output | 8 | Byte offered to the transmitter |
| tx_valid_o | output | 1 | `tx_data_o` holds a byte to send |
| tx_ready_i | input | 1 | Transmitter accepts the byte this cycle |
| frame_done_o | output | 1 | One-cycle pulse after the last byte of a packet is accepted |

## Verification
Two of this block's functions can land in the same cycle:

- **Request and final acceptance:** a new request can arrive in the very cycle the final byte of a packet is accepted, so the pending request and the end of the packet resolve on one edge. The bench raises `start_i` in exactly the cycle that its own byte count marks as the 22nd handshake. It then expects `tx_valid_o` to return right after the `frame_done_o` cycle, carrying a fresh marker.
- **End of packet and relaunch in continuous mode:** the end-of-packet pulse and the relaunch meet on adjacent edges. The bench changes the samples during the first packet and requires the second packet to carry the new values after a one-cycle gap.

// File: rtl/pkt_pkg.sv
package pkt_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;

  typedef enum logic {
    PK_IDLE = 1'b0,
    PK_SEND = 1'b1
  } pk_state_e;
endpackage

// File: rtl/pkt_snapshot.sv
module pkt_snapshot #(
  parameter int NUM_CH   = 10,
  parameter int SAMPLE_W = 12,
  localparam int FLAT_W  = NUM_CH * SAMPLE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture_i,
  input  logic [FLAT_W-1:0] samples_i,
  output logic [FLAT_W-1:0] snap_o
);
  // One register bank per channel, all loaded on the launch edge.
  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic [SAMPLE_W-1:0] held_q;
    always_ff @(posedge clk) begin
      if (!rst_n)
        held_q <= '0;
      else if (capture_i)
        held_q <= samples_i[g*SAMPLE_W +: SAMPLE_W];
    end
    assign snap_o[g*SAMPLE_W +: SAMPLE_W] = held_q;
  end
endmodule

// File: rtl/pkt_byte_sel.sv
module pkt_byte_sel
  import pkt_pkg::*;
#(
  parameter int NUM_CH            = 10,
  parameter int SAMPLE_W          = 12,
  parameter int IDX_W             = 5,
  parameter logic [BYTE_W-1:0] MARKER = 8'hFF,
  localparam int FLAT_W           = NUM_CH * SAMPLE_W
) (
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [FLAT_W-1:0] snap_i,
  output logic [BYTE_W-1:0] byte_o
);
  logic [IDX_W-1:0]    rel;
  logic [IDX_W-1:0]    ch;
  logic [SAMPLE_W-1:0] sample;
  logic [WORD_W-1:0]   word;

  always_comb begin
    rel    = idx_i - IDX_W'(2);
    ch     = rel >> 1;
    sample = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (ch == IDX_W'(c))
        sample = snap_i[c*SAMPLE_W +: SAMPLE_W];
    end
    // Right-aligned in a 16-bit word: the upper bits stay zero.
    word = WORD_W'(sample);
    if (idx_i < IDX_W'(2))
      byte_o = MARKER;
    else if (rel[0])
      byte_o = word[BYTE_W-1:0];
    else
      byte_o = word[WORD_W-1:BYTE_W];
  end
endmodule

// File: rtl/pkt_sequencer.sv
module pkt_sequencer
  import pkt_pkg::*;
#(
  parameter int FRAME_LEN = 22,
  localparam int IDX_W    = $clog2(FRAME_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             continuous_i,
  input  logic             tx_ready_i,
  output logic             capture_o,
  output logic             valid_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             done_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(FRAME_LEN - 1);

  pk_state_e        state_q;
  logic [IDX_W-1:0] idx_q;
  logic             pending_q;
  logic             done_q;
  logic             go;
  logic             fire;

  assign go        = start_i | pending_q | continuous_i;
  assign valid_o   = (state_q == PK_SEND);
  assign fire      = valid_o & tx_ready_i;
  assign capture_o = (state_q == PK_IDLE) & go;
  assign idx_o     = idx_q;
  assign done_o    = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= PK_IDLE;
      idx_q     <= '0;
      pending_q <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        PK_IDLE: begin
          if (go) begin
            state_q   <= PK_SEND;
            idx_q     <= '0;
            pending_q <= 1'b0;
          end
        end
        PK_SEND: begin
          if (start_i)
            pending_q <= 1'b1;
          if (fire) begin
            if (idx_q == LAST) begin
              state_q <= PK_IDLE;
              done_q  <= 1'b1;
            end else begin
              idx_q <= idx_q + IDX_W'(1);
            end
          end
        end
        default: state_q <= PK_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pkt_frame_packer.sv
module pkt_frame_packer
  import pkt_pkg::*;
#(
  parameter int NUM_CH              = 10,
  parameter int SAMPLE_W            = 12,
  parameter logic [7:0] MARKER      = 8'hFF,
  localparam int FLAT_W             = NUM_CH * SAMPLE_W,
  localparam int FRAME_LEN          = 2 + 2 * NUM_CH,
  localparam int IDX_W              = $clog2(FRAME_LEN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FLAT_W-1:0] samples_i,
  input  logic              continuous_i,
  input  logic              start_i,
  output logic [7:0]        tx_data_o,
  output logic              tx_valid_o,
  input  logic              tx_ready_i,
  output logic              frame_done_o
);
  logic              capture;
  logic [IDX_W-1:0]  idx;
  logic [FLAT_W-1:0] snap;

  pkt_sequencer #(.FRAME_LEN(FRAME_LEN)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .continuous_i (continuous_i),
    .tx_ready_i   (tx_ready_i),
    .capture_o    (capture),
    .valid_o      (tx_valid_o),
    .idx_o        (idx),
    .done_o       (frame_done_o)
  );

  pkt_snapshot #(.NUM_CH(NUM_CH), .SAMPLE_W(SAMPLE_W)) u_snap (
    .clk       (clk),
    .rst_n     (rst_n),
    .capture_i (capture),
    .samples_i (samples_i),
    .snap_o    (snap)
  );

  pkt_byte_sel #(
    .NUM_CH   (NUM_CH),
    .SAMPLE_W (SAMPLE_W),
    .IDX_W    (IDX_W),
    .MARKER   (MARKER)
  ) u_sel (
    .idx_i  (idx),
    .snap_i (snap),
    .byte_o (tx_data_o)
  );
endmodule

// File: rtl/pkt_frame_packer_chk.sv
module pkt_frame_packer_chk #(
  parameter int NUM_CH         = 10,
  parameter int SAMPLE_W       = 12,
  parameter logic [7:0] MARKER = 8'hFF,
  localparam int FRAME_LEN     = 2 + 2 * NUM_CH,
  localparam int CNT_W         = $clog2(FRAME_LEN)
) (
  input logic       clk,
  input logic       rst_n,
  input logic       start_i,
  input logic       continuous_i,
  input logic [7:0] tx_data_o,
  input logic       tx_valid_o,
  input logic       tx_ready_i,
  input logic       frame_done_o
);
  // Independent count of accepted bytes within the current packet.
  logic [CNT_W-1:0] cnt_q;
  logic             fire;
  assign fire = tx_valid_o && tx_ready_i;

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (fire)
      cnt_q <= (cnt_q == CNT_W'(FRAME_LEN - 1)) ? '0 : cnt_q + CNT_W'(1);
  end

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |=> (!tx_valid_o && !frame_done_o));

  p_marker_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid_o && cnt_q < CNT_W'(2)) |-> (tx_data_o == MARKER));

  p_upper_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid_o && cnt_q >= CNT_W'(2) && !cnt_q[0])
      |-> ((tx_data_o >> (SAMPLE_W - 8)) == 8'h00));

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid_o && !tx_ready_i) |=> (tx_valid_o && $stable(tx_data_o)));

  p_done_after_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && cnt_q == CNT_W'(FRAME_LEN - 1)) |=> (frame_done_o && !tx_valid_o));

  p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done_o |=> !frame_done_o);

  p_launch_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_valid_o && (start_i || continuous_i)) |=> tx_valid_o);
endmodule

bind pkt_frame_packer pkt_frame_packer_chk #(
  .NUM_CH   (NUM_CH),
  .SAMPLE_W (SAMPLE_W),
  .MARKER   (MARKER)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start_i      (start_i),
  .continuous_i (continuous_i),
  .tx_data_o    (tx_data_o),
  .tx_valid_o   (tx_valid_o),
  .tx_ready_i   (tx_ready_i),
  .frame_done_o (frame_done_o)
);

// File: tb/pkt_frame_packer_bench.sv
`timescale 1ns/1ps
module pkt_frame_packer_bench;
  localparam int NCH = 10;
  localparam int SW  = 12;
  localparam int FL  = 2 + 2 * NCH;

  typedef logic [SW-1:0] sset_t [NCH];
  typedef struct packed {
    logic [11:0] base;
    logic [11:0] step;
    logic [3:0]  stall;
  } vec_t;

  localparam int NVEC = 5;
  localparam vec_t VECS [NVEC] = '{
    '{base: 12'h000, step: 12'h000, stall: 4'd0},
    '{base: 12'hFFF, step: 12'h000, stall: 4'd0},
    '{base: 12'h123, step: 12'h111, stall: 4'd3},
    '{base: 12'h0F0, step: 12'h301, stall: 4'd2},
    '{base: 12'hABC, step: 12'h7FF, stall: 4'd5}
  };

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic [NCH*SW-1:0]  samples_i = '0;
  logic               continuous_i = 1'b0;
  logic               start_i = 1'b0;
  logic [7:0]         tx_data_o;
  logic               tx_valid_o;
  logic               tx_ready_i = 1'b1;
  logic               frame_done_o;

  int n_tests = 0;
  int n_fail  = 0;

  always #2.5 clk = ~clk;

  pkt_frame_packer u_pkt_frame_packer (
    .clk          (clk),
    .rst_n        (rst_n),
    .samples_i    (samples_i),
    .continuous_i (continuous_i),
    .start_i      (start_i),
    .tx_data_o    (tx_data_o),
    .tx_valid_o   (tx_valid_o),
    .tx_ready_i   (tx_ready_i),
    .frame_done_o (frame_done_o)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [NCH*SW-1:0] pack(input sset_t s);
    logic [NCH*SW-1:0] v;
    for (int k = 0; k < NCH; k++) v[k*SW +: SW] = s[k];
    return v;
  endfunction

  function automatic logic [7:0] exp_byte(input sset_t s, input int n);
    if (n < 2) return 8'hFF;
    if (((n - 2) % 2) == 0) return {4'h0, s[(n - 2) / 2][11:8]};
    return s[(n - 2) / 2][7:0];
  endfunction

  function automatic sset_t make_set(input logic [11:0] base, input logic [11:0] step);
    sset_t s;
    for (int k = 0; k < NCH; k++) s[k] = 12'(base + step * 12'(k));
    return s;
  endfunction

  // Pulse start in idle; the byte stream must open in the following cycle.
  task automatic launch();
    start_i = 1'b1;
    tick();
    start_i = 1'b0;
    check(tx_valid_o == 1'b1, "R8", "valid after start", 32'(tx_valid_o), 32'd1);
  endtask

  // Receive one packet; entry and exit at posedge+1.
  task automatic collect(input sset_t exp, input int stall, input bit start_at_last);
    int n = 0;
    int guard = 0;
    while (n < FL && guard < 2000) begin
      logic hv, hr;
      logic [7:0] hd;
      tx_ready_i = (stall == 0) ? 1'b1 : ((guard % stall) != 0);
      hv = tx_valid_o;
      hr = tx_ready_i;
      hd = tx_data_o;
      if (start_at_last && hv && hr && n == FL - 1) start_i = 1'b1;
      if (hv && hr) begin
        check(hd == exp_byte(exp, n), (n < 2) ? "R2" : "R3",
              $sformatf("byte %0d", n), 32'(hd), 32'(exp_byte(exp, n)));
        n++;
      end
      tick();
      start_i = 1'b0;
      if (hv && !hr)
        check(tx_valid_o && tx_data_o == hd, "R4", "hold under stall",
              {23'd0, tx_valid_o, tx_data_o}, {23'd0, 1'b1, hd});
      guard++;
    end
    tx_ready_i = 1'b1;
    check(n == FL, "R5", "bytes in packet", 32'(n), 32'(FL));
    check(frame_done_o && !tx_valid_o, "R5", "done pulse after last byte",
          {30'd0, frame_done_o, tx_valid_o}, 32'd2);
    tick();
    check(!frame_done_o, "R5", "done lasts one cycle", 32'(frame_done_o), 32'd0);
  endtask

  initial begin : watchdog
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    sset_t sa, sb, ones;
    repeat (3) tick();
    check(!tx_valid_o && !frame_done_o, "R1", "outputs in reset",
          {30'd0, tx_valid_o, frame_done_o}, 32'd0);
    rst_n = 1'b1;
    repeat (3) tick();
    check(!tx_valid_o, "R1", "idle without request", 32'(tx_valid_o), 32'd0);

    // Vector table: single-shot packets, changed inputs, varied stalls.
    for (int v = 0; v < NVEC; v++) begin
      sa = make_set(VECS[v].base, VECS[v].step);
      for (int k = 0; k < NCH; k++) ones[k] = ~sa[k];
      samples_i = pack(sa);
      launch();
      samples_i = pack(ones);  // R6: must not reach this packet
      collect(sa, int'(VECS[v].stall), 1'b0);
      repeat (3) tick();
      check(!tx_valid_o, "R8", "single shot stays idle", 32'(tx_valid_o), 32'd0);
    end

    // R9: requests during a stalled packet collapse into one further packet.
    sa = make_set(12'h456, 12'h0A1);
    samples_i = pack(sa);
    launch();
    tx_ready_i = 1'b0;
    start_i = 1'b1; tick(); start_i = 1'b0; tick();
    start_i = 1'b1; tick(); start_i = 1'b0;
    collect(sa, 0, 1'b0);
    check(tx_valid_o, "R9", "held request launches", 32'(tx_valid_o), 32'd1);
    collect(sa, 0, 1'b0);
    repeat (3) tick();
    check(!tx_valid_o, "R9", "requests collapsed", 32'(tx_valid_o), 32'd0);

    // R9: request in the same cycle as the final acceptance.
    launch();
    collect(sa, 0, 1'b1);
    check(tx_valid_o && tx_data_o == 8'hFF, "R9", "collision relaunch",
          {23'd0, tx_valid_o, tx_data_o}, {23'd0, 1'b1, 8'hFF});
    collect(sa, 0, 1'b0);
    repeat (2) tick();

    // R7: continuous mode, fresh snapshot for the second packet.
    sa = make_set(12'h321, 12'h00F);
    sb = make_set(12'hE01, 12'h1F3);
    samples_i = pack(sa);
    continuous_i = 1'b1;
    tick();
    check(tx_valid_o, "R7", "continuous launch", 32'(tx_valid_o), 32'd1);
    samples_i = pack(sb);
    collect(sa, 0, 1'b0);
    check(tx_valid_o, "R7", "one-cycle gap then relaunch", 32'(tx_valid_o), 32'd1);
    continuous_i = 1'b0;
    collect(sb, 2, 1'b0);
    repeat (3) tick();
    check(!tx_valid_o, "R7", "stops after continuous drops", 32'(tx_valid_o), 32'd0);

    // R1: reset in the middle of a packet.
    samples_i = pack(sa);
    launch();
    repeat (4) tick();
    rst_n = 1'b0;
    tick();
    check(!tx_valid_o && !frame_done_o, "R1", "mid-packet reset",
          {30'd0, tx_valid_o, frame_done_o}, 32'd0);
    rst_n = 1'b1;
    repeat (4) tick();
    check(!tx_valid_o, "R1", "quiet after reset", 32'(tx_valid_o), 32'd0);
    launch();
    collect(sa, 0, 1'b0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule